// File: doc/BRIEF.md
# Warp Memory Request Coalescer

This block takes one warp-wide memory request, made of a 32-bit byte address for each of 32 lanes plus an active-lane mask, and folds it into the fewest possible 32-byte segment transactions. Any set of active lanes whose addresses share bits [31:5] is served by one transaction. Lane order, duplicate addresses and misalignment within a segment make no difference. The transactions leave one per cycle on a valid/ready stream, in ascending segment order. Each one carries a bitmap of the lanes it serves.

When a request has been fully emitted, the block pulses a status strobe. With the strobe it gives the bytes the active lanes asked for (4 per lane) and the bytes moved (32 per transaction). The ratio of the two is the bus utilization for that request.

Back-pressure rules are as follows. The request port accepts on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low from the accepting edge until the last transaction has been taken, so only one request is ever in flight. On the output side a transaction moves on an edge where `txn_valid` and `txn_ready` are both high. While `txn_ready` is low, the offered transaction stays unchanged.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, `txn_valid` and `stat_valid` are low and `req_ready` is high.
- R2: An accepted request yields exactly one transaction per distinct segment tag (address bits [31:5]) among its active lanes. Address bits [4:0] and duplicate addresses do not add transactions.
- R3: `txn_lanes` bit i is set exactly when lane i is active and its address lies in the segment given by `txn_seg`; the bitmap is never empty.
- R4: The transactions of one request appear in strictly ascending `txn_seg` order. `txn_last` is high on the final one only.
- R5: `stat_valid` is high for one cycle, in the cycle after the final transaction is taken. With it, `stat_req_bytes` equals 4 × (active lanes) and `stat_moved_bytes` equals 32 × (transactions).
- R6: Lanes with a mask bit of 0 are ignored. An all-zero mask produces no transaction, and `stat_valid` rises with both byte counts 0 in the cycle after acceptance.
- R7: While `txn_valid` is high and `txn_ready` is low, `txn_valid`, `txn_seg`, `txn_lanes` and `txn_last` hold their values into the next cycle.
- R8: `req_ready` is low from the cycle after a request with a nonzero mask is accepted until the cycle after its final transaction is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_mask | input | LANES | Active-lane mask, bit i = lane i |
| req_addr | input | LANES*ADDR_W | Lane byte addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Consumer takes the transaction |
| txn_seg | output | ADDR_W-5 | Segment tag (address bits [31:5]) |
| txn_lanes | output | LANES | Lanes served by this transaction |
| txn_last | output | 1 | Final transaction of the request |
| stat_valid | output | 1 | One-cycle strobe: request finished |
| stat_req_bytes | output | 11 | Bytes requested by active lanes |
| stat_moved_bytes | output | 11 | Bytes moved across the bus |

## Verification
Two events can fall on the same edge: the hand-over of the last transaction of a request, and the release of the request port together with the status strobe. The bench provokes this with a random `txn_ready` pattern that sometimes takes the last transaction at once and sometimes stalls it. It then judges the cycle after that hand-over: the strobe and both byte counts must appear there, `txn_valid` must be low, and the next request must be accepted right away. It also covers a zero mask, where acceptance and completion land one cycle apart with no transaction between.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_SHIFT = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EMIT = 1'b1
  } coal_state_e;
endpackage

// File: rtl/coal_min_tag.sv
// Reduction tree: smallest segment tag among the lanes still pending.
// LANES must be a power of two.
module coal_min_tag #(
  parameter int LANES = 32,
  parameter int TAG_W = 27
) (
  input  logic [LANES-1:0]       pend,
  input  logic [LANES*TAG_W-1:0] tags,
  output logic                   found,
  output logic [TAG_W-1:0]       min_tag
);
  logic             vv [LANES];
  logic [TAG_W-1:0] tt [LANES];

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      vv[i] = pend[i];
      tt[i] = tags[i*TAG_W +: TAG_W];
    end
    // in-place pairwise fold; node i reads 2i and 2i+1, never already overwritten
    for (int w = LANES / 2; w >= 1; w = w / 2) begin
      for (int i = 0; i < w; i++) begin
        if (vv[2*i] && (!vv[2*i+1] || (tt[2*i] <= tt[2*i+1]))) begin
          tt[i] = tt[2*i];
        end else begin
          tt[i] = tt[2*i+1];
        end
        vv[i] = vv[2*i] | vv[2*i+1];
      end
    end
    found   = vv[0];
    min_tag = tt[0];
  end
endmodule

// File: rtl/coal_lane_match.sv
// One comparator per lane: which pending lanes fall in the chosen segment.
module coal_lane_match #(
  parameter int LANES = 32,
  parameter int TAG_W = 27
) (
  input  logic [LANES-1:0]       pend,
  input  logic [LANES*TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]       key,
  output logic [LANES-1:0]       hit
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign hit[i] = pend[i] && (tags[i*TAG_W +: TAG_W] == key);
  end
endmodule

// File: rtl/coal_popcount.sv
module coal_popcount #(
  parameter int W   = 32,
  parameter int CW  = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits_in,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < W; i++) begin
      count = count + CW'(bits_in[i]);
    end
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coal_pkg::*;
#(
  parameter int LANES     = 32,
  parameter int ADDR_W    = 32,
  parameter int SEG_BYTES = 32
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_valid,
  output logic                                  req_ready,
  input  logic [LANES-1:0]                      req_mask,
  input  logic [LANES*ADDR_W-1:0]               req_addr,
  output logic                                  txn_valid,
  input  logic                                  txn_ready,
  output logic [ADDR_W-$clog2(SEG_BYTES)-1:0]   txn_seg,
  output logic [LANES-1:0]                      txn_lanes,
  output logic                                  txn_last,
  output logic                                  stat_valid,
  output logic [$clog2(LANES*SEG_BYTES+1)-1:0]  stat_req_bytes,
  output logic [$clog2(LANES*SEG_BYTES+1)-1:0]  stat_moved_bytes
);
  localparam int SEG_SHIFT = $clog2(SEG_BYTES);
  localparam int TAG_W     = ADDR_W - SEG_SHIFT;
  localparam int CNT_W     = $clog2(LANES + 1);
  localparam int BYTES_W   = $clog2(LANES * SEG_BYTES + 1);

  coal_state_e              state_q;
  logic [LANES-1:0]         pend_q;
  logic [LANES*TAG_W-1:0]   tags_q;
  logic [LANES*TAG_W-1:0]   tags_in;
  logic [BYTES_W-1:0]       req_bytes_q;
  logic [BYTES_W-1:0]       moved_q;
  logic                     stat_q;
  logic [CNT_W-1:0]         active_cnt;
  logic                     found;
  logic [TAG_W-1:0]         min_tag;
  logic [LANES-1:0]         hit;
  logic                     accept;
  logic                     take;

  for (genvar i = 0; i < LANES; i++) begin : g_tag
    assign tags_in[i*TAG_W +: TAG_W] = req_addr[i*ADDR_W + SEG_SHIFT +: TAG_W];
  end

  coal_popcount #(.W(LANES), .CW(CNT_W)) u_cnt (
    .bits_in (req_mask),
    .count   (active_cnt)
  );

  coal_min_tag #(.LANES(LANES), .TAG_W(TAG_W)) u_min (
    .pend    (pend_q),
    .tags    (tags_q),
    .found   (found),
    .min_tag (min_tag)
  );

  coal_lane_match #(.LANES(LANES), .TAG_W(TAG_W)) u_match (
    .pend (pend_q),
    .tags (tags_q),
    .key  (min_tag),
    .hit  (hit)
  );

  assign req_ready        = (state_q == ST_IDLE);
  assign accept           = req_valid && req_ready;
  assign txn_valid        = (state_q == ST_EMIT) && found;
  assign txn_seg          = min_tag;
  assign txn_lanes        = hit;
  assign txn_last         = ((pend_q & ~hit) == '0);
  assign take             = txn_valid && txn_ready;
  assign stat_valid       = stat_q;
  assign stat_req_bytes   = req_bytes_q;
  assign stat_moved_bytes = moved_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      pend_q      <= '0;
      tags_q      <= '0;
      req_bytes_q <= '0;
      moved_q     <= '0;
      stat_q      <= 1'b0;
    end else begin
      stat_q <= 1'b0;
      if (accept) begin
        pend_q      <= req_mask;
        tags_q      <= tags_in;
        req_bytes_q <= BYTES_W'(active_cnt) << WORD_SHIFT;
        moved_q     <= '0;
        if (req_mask == '0) begin
          stat_q <= 1'b1;
        end else begin
          state_q <= ST_EMIT;
        end
      end else if (take) begin
        pend_q  <= pend_q & ~hit;
        moved_q <= moved_q + BYTES_W'(SEG_BYTES);
        if (txn_last) begin
          state_q <= ST_IDLE;
          stat_q  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
  parameter int LANES = 32,
  parameter int TAG_W = 27
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LANES-1:0] req_mask,
  input logic             txn_valid,
  input logic             txn_ready,
  input logic [TAG_W-1:0] txn_seg,
  input logic [LANES-1:0] txn_lanes,
  input logic             txn_last,
  input logic             stat_valid
);
  AST_LANES_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_lanes != '0)); // R3

  AST_SEG_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_ready && !txn_last) |=> (txn_valid && (txn_seg > $past(txn_seg)))); // R4

  AST_STAT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_ready && txn_last) |=> (stat_valid && !txn_valid)); // R5

  AST_EMPTY_MASK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_mask == '0)) |=> (stat_valid && !txn_valid)); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_seg) && $stable(txn_lanes) && $stable(txn_last))); // R7

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> !req_ready); // R8

  AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_ready && txn_last) |=> req_ready); // R8
endmodule

bind warp_coalescer coal_checker #(
  .LANES (LANES),
  .TAG_W (ADDR_W - $clog2(SEG_BYTES))
) u_chk (.*);

// File: tb/sim_warp_coalescer.sv
module sim_warp_coalescer;
  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 32;
  localparam int ADDR_W     = 32;
  localparam int TAG_W      = 27;
  localparam int BW         = 11;
  localparam int WD_CYCLES  = 150000;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    req_valid = 1'b0;
  logic                    req_ready;
  logic [LANES-1:0]        req_mask = '0;
  logic [LANES*ADDR_W-1:0] req_addr = '0;
  logic                    txn_valid;
  logic                    txn_ready = 1'b0;
  logic [TAG_W-1:0]        txn_seg;
  logic [LANES-1:0]        txn_lanes;
  logic                    txn_last;
  logic                    stat_valid;
  logic [BW-1:0]           stat_req_bytes;
  logic [BW-1:0]           stat_moved_bytes;

  int checks = 0;
  int errors = 0;

  logic [31:0]      addr [LANES];
  logic [TAG_W-1:0] exp_seg [LANES];
  logic [LANES-1:0] exp_lanes [LANES];
  int               exp_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_coalescer u0 (
    .clk, .rst_n, .req_valid, .req_ready, .req_mask, .req_addr,
    .txn_valid, .txn_ready, .txn_seg, .txn_lanes, .txn_last,
    .stat_valid, .stat_req_bytes, .stat_moved_bytes
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // expected transactions: repeatedly pick the smallest remaining segment
  task automatic compute_expected(input logic [LANES-1:0] m);
    logic [LANES-1:0] left;
    logic [TAG_W-1:0] best;
    left  = m;
    exp_n = 0;
    while (left != '0) begin
      best = '1;
      for (int i = 0; i < LANES; i++)
        if (left[i] && addr[i][31:5] <= best) best = addr[i][31:5];
      exp_lanes[exp_n] = '0;
      for (int i = 0; i < LANES; i++)
        if (left[i] && addr[i][31:5] == best) exp_lanes[exp_n][i] = 1'b1;
      exp_seg[exp_n] = best;
      left = left & ~exp_lanes[exp_n];
      exp_n++;
    end
  endtask

  task automatic run_req(input logic [LANES-1:0] m);
    int k;
    int guard;
    bit stalled;
    logic [TAG_W-1:0] h_seg;
    logic [LANES-1:0] h_lanes;
    logic             h_last;
    compute_expected(m);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_mask = m;
    for (int i = 0; i < LANES; i++) req_addr[i*ADDR_W +: ADDR_W] = addr[i];
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_n == 0) begin
      check(stat_valid && !txn_valid, "R6", "zero mask strobe/valid",
            {stat_valid, txn_valid}, 2'b10);
      check(stat_req_bytes == 0 && stat_moved_bytes == 0, "R6", "zero mask bytes",
            {stat_req_bytes, stat_moved_bytes}, 0);
      return;
    end
    check(!req_ready, "R8", "req_ready while busy", req_ready, 0);
    k = 0; guard = 0; stalled = 1'b0;
    h_seg = '0; h_lanes = '0; h_last = 1'b0;
    while (k < exp_n && guard < 1000) begin
      guard++;
      if (!txn_valid) begin
        check(1'b0, "R2", "txn_valid dropped early", k, exp_n);
        break;
      end
      if (stalled)
        check(txn_seg == h_seg && txn_lanes == h_lanes && txn_last == h_last,
              "R7", "held under stall", txn_lanes, h_lanes);
      txn_ready = ($urandom % 4) != 0;
      if (txn_ready) begin
        check(txn_seg == exp_seg[k], "R4", "segment order", txn_seg, exp_seg[k]);
        check(txn_lanes == exp_lanes[k], "R3", "lane bitmap", txn_lanes, exp_lanes[k]);
        check(txn_last == (k == exp_n - 1), "R4", "last flag", txn_last, k == exp_n - 1);
        k++;
        stalled = 1'b0;
      end else begin
        stalled = 1'b1;
        h_seg = txn_seg; h_lanes = txn_lanes; h_last = txn_last;
      end
      @(negedge clk);
    end
    txn_ready = 1'b0;
    check(stat_valid && !txn_valid, "R5", "strobe after last", {stat_valid, txn_valid}, 2'b10);
    check(stat_req_bytes == BW'($countones(m) * 4), "R5", "requested bytes",
          stat_req_bytes, $countones(m) * 4);
    check(stat_moved_bytes == BW'(exp_n * 32), "R2", "moved bytes",
          stat_moved_bytes, exp_n * 32);
    check(req_ready, "R8", "ready after last", req_ready, 1);
  endtask

  task automatic run_all();
    logic [31:0] base;
    int perm [LANES];
    int t;
    int j;
    // R1: reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!txn_valid && !stat_valid && req_ready, "R1", "reset outputs",
          {txn_valid, stat_valid, req_ready}, 3'b001);

    // R2: aligned consecutive words -> 4 transactions
    for (int i = 0; i < LANES; i++) addr[i] = 32'h0000_1000 + i * 4;
    run_req('1);
    // R2/R3: permuted aligned words -> still 4
    for (int i = 0; i < LANES; i++) perm[i] = i;
    for (int i = LANES - 1; i > 0; i--) begin
      j = $urandom % (i + 1); t = perm[i]; perm[i] = perm[j]; perm[j] = t;
    end
    for (int i = 0; i < LANES; i++) addr[i] = 32'h0000_2000 + perm[i] * 4;
    run_req('1);
    // R2: offset by one word -> 5 transactions
    for (int i = 0; i < LANES; i++) addr[i] = 32'h0000_3004 + i * 4;
    run_req('1);
    // R2: offset by one segment -> 4 transactions
    for (int i = 0; i < LANES; i++) addr[i] = 32'h0000_3020 + i * 4;
    run_req('1);
    // R2: every lane on one word -> 1 transaction, 128 requested, 32 moved
    for (int i = 0; i < LANES; i++) addr[i] = 32'hFFFF_FFFC;
    run_req('1);
    // R6: zero mask, then a sparse mask ignoring far-away inactive lanes
    for (int i = 0; i < LANES; i++) addr[i] = (i % 2) ? 32'h8000_0000 + i * 64 : 32'h10 + i * 4;
    run_req('0);
    run_req(32'h5555_5555);
    run_req(32'h0000_0001);

    // random mix (R2..R8)
    for (int r = 0; r < 150; r++) begin
      base = {$urandom, 2'b00};
      for (int i = 0; i < LANES; i++) begin
        if (r % 5 == 4) addr[i] = {$urandom, 2'b00};
        else addr[i] = base + ($urandom % 64) * 4;
      end
      if (r % 4 == 0) run_req('1);
      else if (r % 17 == 0) run_req('0);
      else run_req($urandom);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    fork
      run_all();
      begin
        repeat (WD_CYCLES) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", WD_CYCLES, WD_CYCLES);
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule